// File: doc/BRIEF.md
# Dual-Stream Line Number and CRC Inserter

This block sits downstream of the active-video multiplexer on a 20-bit virtual interface. The interface is made of two parallel 10-bit word streams that share one clock. A strobe marks the end word of each end-of-active-video timing reference. The block then replaces the next four words of both streams. The first two carry the current line number and the last two carry an 18-bit line check code. Every other word passes through unchanged, with one cycle of latency.

Each stream has its own check-code accumulator. A second strobe marks the first active word of a line. The accumulator is cleared on that word and runs through the active data, the timing reference and both inserted line-number words. It then holds its value while the two check words are emitted. The line number is captured on the timing-reference end word, so the input may change freely after that point.

Top module: `ln_crc_inserter`

## Requirements
- R1: While rst_ni is low, both output streams are 0.
- R2: Any input word not in insertion slots 1..4 after an end strobe appears unchanged on its output one clock later. Slot k is the k-th word after the word carrying eav_end_i.
- R3: Slot 1 becomes the low line word on both streams. Its bits 8..2 hold line bits 6..0, bits 1..0 are 0, and bit 9 is the inverse of bit 8.
- R4: Slot 2 becomes the high line word on both streams. Its bits 5..2 hold line bits 10..7, bits 8..6 and 1..0 are 0, and bit 9 is 1.
- R5: The line number used in slots 1 and 2 is the value of line_i on the eav_end_i word. Later changes to line_i have no effect on that pair.
- R6: Each check code uses the polynomial x^18+x^5+x^4+1, taken LSB first within each word. The register shifts right, the feedback is reg[0] xor the data bit, and the feedback is xored into bits 17, 13 and 12 after the shift. The code starts from zero on the act_start_i word and covers that word through the slot-2 word, using the substituted line words.
- R7: Slot 3 carries code bits 8..0 and slot 4 carries code bits 17..9, both in bits 8..0. Bit 9 of each is the inverse of bit 8.
- R8: The two streams keep separate codes. Each code depends only on its own stream's words.
- R9: Words after slot 2 and before the next act_start_i are not accumulated. With no act_start_i since reset, slots 3 and 4 both read 10'h200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ds1_i | input | 10 | Stream one input word |
| ds2_i | input | 10 | Stream two input word |
| act_start_i | input | 1 | Marks the first active word of a line |
| eav_end_i | input | 1 | Marks the last word of the end timing reference |
| line_i | input | 11 | Current line number |
| ds1_o | output | 10 | Stream one output word |
| ds2_o | output | 10 | Stream two output word |

## Verification
The bench drives junk on line_i and on the input words of all four slots, while the line number is valid only on the end-strobe word. A design that samples late, or that lets a slot word through, would show the wrong line words. It checks line numbers 0, 2047 and alternating-bit patterns, and active lengths down to a single word. A wrong bit slice or a wrong bit-9 rule would show up in these cases. One line has nearly identical streams, so a shared or cross-wired accumulator would produce equal codes. The bench also puts random blanking words between lines and runs an end strobe before any active start. A design that never stops accumulating, or never clears, would then emit codes that do not match the reference model.

// File: rtl/ln_crc_pkg.sv
package ln_crc_pkg;
  localparam int WORD_W = 10;
  localparam int CRC_W  = 18;
  localparam int LINE_W = 11;
  // taps after right shift for x^18 + x^5 + x^4 + 1, LSB-first
  localparam logic [CRC_W-1:0] CRC_TAPS = (CRC_W'(1) << (CRC_W-1)) |
                                          (CRC_W'(1) << (CRC_W-5)) |
                                          (CRC_W'(1) << (CRC_W-6));

  typedef enum logic [2:0] {
    SLOT_IDLE, SLOT_LN0, SLOT_LN1, SLOT_CR0, SLOT_CR1
  } slot_e;

  function automatic logic [CRC_W-1:0] crc_word_step(
    input logic [CRC_W-1:0]  c,
    input logic [WORD_W-1:0] w
  );
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[0] ^ w[i];
      r  = (r >> 1) ^ (fb ? CRC_TAPS : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/ins_slot_seq.sv
module ins_slot_seq
  import ln_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eav_end_i,
  input  logic [LINE_W-1:0] line_i,
  output slot_e             slot_o,
  output logic [LINE_W-1:0] line_o
);
  slot_e slot_q, slot_d;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    if (eav_end_i) slot_d = SLOT_LN0;
    else begin
      case (slot_q)
        SLOT_LN0: slot_d = SLOT_LN1;
        SLOT_LN1: slot_d = SLOT_CR0;
        SLOT_CR0: slot_d = SLOT_CR1;
        default:  slot_d = SLOT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT_IDLE;
      line_q <= '0;
    end else begin
      slot_q <= slot_d;
      if (eav_end_i) line_q <= line_i;
    end
  end

  assign slot_o = slot_q;
  assign line_o = line_q;

  AST_SLOT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_end_i |=> slot_q == SLOT_LN0); // R3
  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SLOT_LN0 && !eav_end_i) |=> slot_q == SLOT_LN1); // R4
  AST_LINE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eav_end_i |=> $stable(line_q)); // R5
endmodule

// File: rtl/ln_word_enc.sv
module ln_word_enc
  import ln_crc_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  output logic [WORD_W-1:0] ln0_o,
  output logic [WORD_W-1:0] ln1_o
);
  always_comb begin
    ln0_o = {~line_i[6], line_i[6:0], 2'b00};
    ln1_o = {1'b1, 3'b000, line_i[10:7], 2'b00};
  end
endmodule

// File: rtl/ln_crc_lane.sv
module ln_crc_lane
  import ln_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_start_i,
  input  slot_e             slot_i,
  input  logic [WORD_W-1:0] ln0_i,
  input  logic [WORD_W-1:0] ln1_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CRC_W-1:0]  crc_q;
  logic              acc_on_q;
  logic [WORD_W-1:0] sub_w;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    case (slot_i)
      SLOT_LN0: sub_w = ln0_i;
      SLOT_LN1: sub_w = ln1_i;
      SLOT_CR0: sub_w = {~crc_q[8], crc_q[8:0]};
      SLOT_CR1: sub_w = {~crc_q[17], crc_q[17:9]};
      default:  sub_w = word_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q    <= '0;
      acc_on_q <= 1'b0;
      word_q   <= '0;
    end else begin
      word_q <= sub_w;
      if (act_start_i) begin
        crc_q    <= crc_word_step('0, sub_w);
        acc_on_q <= 1'b1;
      end else begin
        if (acc_on_q) crc_q <= crc_word_step(crc_q, sub_w);
        if (slot_i == SLOT_LN1) acc_on_q <= 1'b0;
      end
    end
  end

  assign word_o = word_q;

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_start_i && !acc_on_q) |=> $stable(crc_q)); // R9
  AST_ACC_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == SLOT_LN1 && !act_start_i) |=> !acc_on_q); // R6
  AST_B9_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != SLOT_IDLE) |=> (word_o[9] == ~word_o[8])); // R7
  AST_RESV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == SLOT_LN0 || slot_i == SLOT_LN1) |=> word_o[1:0] == 2'b00); // R3
endmodule

// File: rtl/ln_crc_inserter.sv
module ln_crc_inserter
  import ln_crc_pkg::*;
#(
  parameter int NUM_STREAMS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [9:0]  ds1_i,
  input  logic [9:0]  ds2_i,
  input  logic        act_start_i,
  input  logic        eav_end_i,
  input  logic [10:0] line_i,
  output logic [9:0]  ds1_o,
  output logic [9:0]  ds2_o
);
  slot_e             slot_w;
  logic [LINE_W-1:0] line_w;
  logic [WORD_W-1:0] ln0_w, ln1_w;
  logic [WORD_W-1:0] in_w  [NUM_STREAMS];
  logic [WORD_W-1:0] out_w [NUM_STREAMS];

  assign in_w[0] = ds1_i;
  assign in_w[1] = ds2_i;

  ins_slot_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eav_end_i (eav_end_i),
    .line_i    (line_i),
    .slot_o    (slot_w),
    .line_o    (line_w)
  );

  ln_word_enc i_enc (
    .line_i (line_w),
    .ln0_o  (ln0_w),
    .ln1_o  (ln1_w)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    ln_crc_lane i_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_start_i (act_start_i),
      .slot_i      (slot_w),
      .ln0_i       (ln0_w),
      .ln1_i       (ln1_w),
      .word_i      (in_w[s]),
      .word_o      (out_w[s])
    );
  end

  assign ds1_o = out_w[0];
  assign ds2_o = out_w[1];

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_w == SLOT_IDLE) |=> (ds1_o == $past(ds1_i) && ds2_o == $past(ds2_i))); // R2
endmodule

// File: tb/test_ln_crc_inserter.sv
module test_ln_crc_inserter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  ds1_i = '0, ds2_i = '0;
  logic        act_start_i = 1'b0, eav_end_i = 1'b0;
  logic [10:0] line_i = '0;
  logic [9:0]  ds1_o, ds2_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int unsigned rng = 32'h1;

  always #10 clk = ~clk;

  ln_crc_inserter i_ln_crc_inserter (
    .clk_i(clk), .rst_ni(rst_ni), .ds1_i(ds1_i), .ds2_i(ds2_i),
    .act_start_i(act_start_i), .eav_end_i(eav_end_i), .line_i(line_i),
    .ds1_o(ds1_o), .ds2_o(ds2_o)
  );

  // {line[10:0], active_len[7:0], seed[15:0]}
  localparam logic [34:0] VEC [6] = '{
    {11'd0,    8'd8,  16'h1234},
    {11'd2047, 8'd1,  16'hBEEF},
    {11'd1125, 8'd20, 16'h0F0F},
    {11'h555,  8'd5,  16'h0001},
    {11'h2AA,  8'd33, 16'hA5A5},
    {11'd42,   8'd12, 16'h7777}
  };

  function automatic logic [9:0] rnd10();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng[25:16];
  endfunction

  // reference: x^18 + x^5 + x^4 + 1, LSB first, right-shifting register
  function automatic logic [17:0] ref_crc(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 10; i++) begin
      fb = r[0] ^ w[i];
      r = r >> 1;
      if (fb) begin
        r[17] = ~r[17];
        r[13] = ~r[13];
        r[12] = ~r[12];
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] a, input logic [9:0] b, input logic s, input logic e,
                     input logic [10:0] l, output logic [9:0] oa, output logic [9:0] ob);
    ds1_i = a; ds2_i = b; act_start_i = s; eav_end_i = e; line_i = l;
    @(posedge clk);
    @(negedge clk);
    oa = ds1_o; ob = ds2_o;
  endtask

  task automatic run_line(input logic [10:0] ln, input int len, input bit mirror, input bit do_start);
    logic [17:0] c1, c2;
    logic [9:0] a, b, oa, ob, ln0, ln1;
    logic [9:0] eav [4];
    eav[0] = 10'h3FF; eav[1] = 10'h000; eav[2] = 10'h000; eav[3] = 10'h274;
    c1 = '0; c2 = '0;
    for (int k = 0; k < len; k++) begin
      a = rnd10();
      b = mirror ? ((k == 0) ? (a ^ 10'h001) : a) : rnd10();
      put(a, b, do_start && (k == 0), 1'b0, rnd10()[10:0] ^ 11'h7FF, oa, ob);
      chk(oa == a, "R2 pass active s1", oa, a);
      chk(ob == b, "R2 pass active s2", ob, b);
      c1 = ref_crc(c1, a); c2 = ref_crc(c2, b);
    end
    for (int k = 0; k < 4; k++) begin
      put(eav[k], eav[k], 1'b0, k == 3, (k == 3) ? ln : ~ln, oa, ob);
      chk(oa == eav[k] && ob == eav[k], "R2 pass eav", oa, eav[k]);
      c1 = ref_crc(c1, eav[k]); c2 = ref_crc(c2, eav[k]);
    end
    ln0 = {~ln[6], ln[6:0], 2'b00};
    ln1 = {1'b1, 3'b000, ln[10:7], 2'b00};
    if (!do_start) begin c1 = '0; c2 = '0; end
    else begin
      c1 = ref_crc(ref_crc(c1, ln0), ln1);
      c2 = ref_crc(ref_crc(c2, ln0), ln1);
    end
    // line_i driven with junk during the slots: R5
    put(rnd10(), rnd10(), 1'b0, 1'b0, ~ln, oa, ob);
    chk(oa == ln0, "R3 R5 ln0 s1", oa, ln0);
    chk(ob == ln0, "R3 R5 ln0 s2", ob, ln0);
    put(rnd10(), rnd10(), 1'b0, 1'b0, ln ^ 11'h5A5, oa, ob);
    chk(oa == ln1, "R4 R5 ln1 s1", oa, ln1);
    chk(ob == ln1, "R4 R5 ln1 s2", ob, ln1);
    put(rnd10(), rnd10(), 1'b0, 1'b0, rnd10()[10:0], oa, ob);
    chk(oa == {~c1[8], c1[8:0]}, "R6 R7 cr0 s1", oa, {~c1[8], c1[8:0]});
    chk(ob == {~c2[8], c2[8:0]}, "R7 R8 cr0 s2", ob, {~c2[8], c2[8:0]});
    put(rnd10(), rnd10(), 1'b0, 1'b0, rnd10()[10:0], oa, ob);
    chk(oa == {~c1[17], c1[17:9]}, "R6 R7 cr1 s1", oa, {~c1[17], c1[17:9]});
    chk(ob == {~c2[17], c2[17:9]}, "R7 R8 cr1 s2", ob, {~c2[17], c2[17:9]});
    if (mirror) chk(c1 != c2 && oa != ob, "R8 separate codes", ob, oa);
    for (int k = 0; k < 6; k++) begin
      a = rnd10(); b = rnd10();
      put(a, b, 1'b0, 1'b0, rnd10()[10:0], oa, ob);
      chk(oa == a && ob == b, "R2 R9 blanking pass", oa, a);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ds1_o == '0, "R1 reset s1", ds1_o, '0);
    chk(ds2_o == '0, "R1 reset s2", ds2_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    // no active start since reset: zero code, R9
    run_line(11'd7, 3, 1'b0, 1'b0);
    for (int v = 0; v < 6; v++) begin
      rng = 32'(VEC[v][15:0]) | 32'h10000;
      run_line(VEC[v][34:24], int'(VEC[v][23:16]), 1'b0, 1'b1);
    end
    rng = 32'h2468;
    run_line(11'h3C3, 10, 1'b1, 1'b1); // R8 near-identical streams
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule